// File: doc/BRIEF.md
# Station Address PROM Loader

This block runs once after power-up, or whenever software or a reset sequencer asks, to fetch a network station address from a small read-only memory. The memory holds eight bytes, placed sixteen bytes apart in its address space. Each byte is stored with its bits in reverse order.

A pulse on `start` makes the loader issue eight byte reads, one at a time. Each read waits for the memory's valid handshake before the next one is issued. Every byte is bit-reversed as it arrives. The first six reversed bytes are assembled into a 48-bit address, with the first byte in the most significant position. All eight reversed bytes are folded together with XOR.

When the last byte has been taken, `done` pulses for one cycle. In that same cycle `csum_err` shows whether the XOR result missed the expected value 0xFF. The address and the flag then hold their values until the next start.

Top module: `sa_prom_loader`

## Requirements
- R1: After reset, `rd_req` and `done` are 0, `csum_err` is 0 and `station_addr` is all zeros.
- R2: A `start` pulse while no read pass is running raises `rd_req` in the next cycle, with `rd_addr` equal to the base address (0 by default).
- R3: Byte j (0 to 7) is requested at `rd_addr` = base + 16×j, in increasing j. Each request follows the handshake of the one before it.
- R4: `rd_req` and `rd_addr` stay unchanged until `rd_valid` is seen high. A `rd_valid` pulse while `rd_req` is low is ignored and changes no output.
- R5: Each byte taken is bit-reversed before use: bit i of `rd_data` becomes bit 7−i.
- R6: `station_addr[47:40]` holds reversed byte 0, and so on down to `station_addr[7:0]`, which holds reversed byte 5. Bytes 6 and 7 do not change the address.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that takes the eighth byte. In that cycle `rd_req` is low and `csum_err` is 1 exactly when the XOR of the eight reversed bytes differs from 0xFF.
- R8: A `start` pulse that is accepted clears `station_addr` and `csum_err` at the next clock edge, including a start given in the cycle `done` is high.
- R9: A `start` pulse while a read pass is running is ignored. The pass carries on with the same address sequence and the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read the PROM |
| rd_req | output | 1 | Byte read request, held until `rd_valid` |
| rd_addr | output | 8 | Byte address of the current request |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 8 | Byte returned by the PROM |
| station_addr | output | 48 | Assembled station address, byte 0 in the top octet |
| done | output | 1 | One-cycle pulse when the pass finishes |
| csum_err | output | 1 | XOR check failed; valid from `done` until the next start |

## Verification
Two events can fall in the same cycle.

The first pair is the taking of the eighth byte and the loader's own status update. The address, the checksum flag and `done` all change on the one edge that takes the last byte. The bench samples all three in the following cycle and compares them against values it computes itself from the random PROM image.

The second pair is a new `start` and the `done` pulse of the previous pass. The bench raises `start` in the `done` cycle. It checks that the old result is visible during that cycle, and that the result is cleared one edge later as the new pass begins. A `start` placed in the middle of a pass, while a request is waiting, must leave the address sequence and the final result unchanged.

// File: rtl/sa_prom_pkg.sv
package sa_prom_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_READ = 1'b1
  } seq_state_t;

  localparam logic [7:0] SA_CHECK_DEFAULT = 8'hFF;
endpackage

// File: rtl/sa_bitrev.sv
module sa_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end

  always_comb begin
    assert_rev_ends_R5: assert (dout[0] == din[W-1] && dout[W-1] == din[0]);
  end
endmodule

// File: rtl/sa_read_seq.sv
module sa_read_seq
  import sa_prom_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int STRIDE    = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0,
  localparam int IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              clear,
  output logic              accept,
  output logic              last,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(BASE_ADDR);
  localparam logic [IDX_W-1:0]  LAST_I = IDX_W'(NUM_BYTES - 1);

  seq_state_t state;

  assign clear  = start && (state == SEQ_IDLE);
  assign accept = rd_req && rd_valid;
  assign last   = (idx == LAST_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= BASE;
      idx     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state   <= SEQ_READ;
            rd_req  <= 1'b1;
            rd_addr <= BASE;
            idx     <= '0;
          end
        end
        SEQ_READ: begin
          if (accept) begin
            if (last) begin
              state  <= SEQ_IDLE;
              rd_req <= 1'b0;
              done   <= 1'b1;
            end else begin
              idx     <= idx + 1'b1;
              rd_addr <= rd_addr + STEP;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_stride_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !last) |=> (rd_addr == $past(rd_addr) + STEP));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_start_first_R2: assert property (@(posedge clk) disable iff (rst)
    clear |=> (rd_req && rd_addr == BASE));
endmodule

// File: rtl/sa_csum.sv
module sa_csum #(
  parameter int         DATA_W = 8,
  parameter logic [7:0] TARGET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              accept,
  input  logic              last,
  input  logic [DATA_W-1:0] byte_in,
  output logic              err
);
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] acc_next;

  assign acc_next = acc ^ byte_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      err <= 1'b0;
    end else if (clear) begin
      acc <= '0;
      err <= 1'b0;
    end else if (accept) begin
      acc <= acc_next;
      if (last) err <= (acc_next != DATA_W'(TARGET));
    end
  end

  assert_clear_err_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !err);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(accept && last)) |=> $stable(err));
endmodule

// File: rtl/sa_addr_asm.sv
module sa_addr_asm #(
  parameter int KEEP   = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  localparam int AW    = KEEP * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              accept,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] byte_in,
  output logic [AW-1:0]     addr
);
  logic keep_it;

  assign keep_it = int'(idx) < KEEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (clear) begin
      addr <= '0;
    end else if (accept && keep_it) begin
      addr <= {addr[AW-DATA_W-1:0], byte_in};
    end
  end

  assert_tail_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !keep_it && !clear) |=> $stable(addr));

  assert_clear_addr_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (addr == '0));
endmodule

// File: rtl/sa_prom_loader.sv
module sa_prom_loader
  import sa_prom_pkg::*;
#(
  parameter int         NUM_BYTES  = 8,
  parameter int         KEEP_BYTES = 6,
  parameter int         STRIDE     = 16,
  parameter int         ADDR_W     = 8,
  parameter int         BASE_ADDR  = 0,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] CHECK_VAL  = SA_CHECK_DEFAULT
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  output logic                         rd_req,
  output logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rd_valid,
  input  logic [DATA_W-1:0]            rd_data,
  output logic [KEEP_BYTES*DATA_W-1:0] station_addr,
  output logic                         done,
  output logic                         csum_err
);
  localparam int IDX_W = $clog2(NUM_BYTES);

  logic              clear;
  logic              accept;
  logic              last;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rev_byte;

  sa_read_seq #(
    .NUM_BYTES(NUM_BYTES),
    .STRIDE(STRIDE),
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid),
    .rd_req(rd_req), .rd_addr(rd_addr), .done(done),
    .clear(clear), .accept(accept), .last(last), .idx(idx)
  );

  sa_bitrev #(.W(DATA_W)) u_rev (
    .din(rd_data), .dout(rev_byte)
  );

  sa_csum #(.DATA_W(DATA_W), .TARGET(CHECK_VAL)) u_csum (
    .clk(clk), .rst(rst), .clear(clear), .accept(accept),
    .last(last), .byte_in(rev_byte), .err(csum_err)
  );

  sa_addr_asm #(.KEEP(KEEP_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_asm (
    .clk(clk), .rst(rst), .clear(clear), .accept(accept),
    .idx(idx), .byte_in(rev_byte), .addr(station_addr)
  );

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);

  assert_idle_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && rd_valid && !start) |=> ($stable(station_addr) && $stable(csum_err)));
endmodule

// File: tb/sa_prom_loader_tb.sv
module sa_prom_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic [47:0] station_addr;
  logic        done;
  logic        csum_err;

  logic [7:0] rom [8];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sa_prom_loader dut_i (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .station_addr(station_addr),
    .done(done), .csum_err(csum_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual %0d expected below 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [47:0] exp_addr();
    logic [47:0] a = '0;
    for (int i = 0; i < 6; i++) a = {a[39:0], rev8(rom[i])};
    return a;
  endfunction

  function automatic logic exp_err();
    logic [7:0] x = '0;
    for (int i = 0; i < 8; i++) x ^= rev8(rom[i]);
    return x != 8'hFF;
  endfunction

  // kind 0: valid checksum, 1: random, 2: all zero, 3: walking pattern, valid
  task automatic load_rom(input int kind);
    logic [7:0] x;
    for (int i = 0; i < 8; i++) begin
      case (kind)
        2: rom[i] = 8'h00;
        3: rom[i] = 8'h01 << i;
        default: rom[i] = 8'($urandom);
      endcase
    end
    if (kind == 0 || kind == 3) begin
      x = 8'hFF;
      for (int i = 0; i < 7; i++) x ^= rev8(rom[i]);
      rom[7] = rev8(x);
    end
  endtask

  // Starts at a negedge with rd_req high; ends at the negedge after the last handshake.
  task automatic feed(input bit mid_start);
    int d;
    for (int j = 0; j < 8; j++) begin
      chk("R3 rd_addr", 64'(rd_addr), 64'(j * 16));
      chk("R4 rd_req held", 64'(rd_req), 64'd1);
      chk("R7 done early", 64'(done), 64'd0);
      d = $urandom % 4;
      if (mid_start && j == 3 && d == 0) d = 1;
      for (int k = 0; k < d; k++) begin
        if (mid_start && j == 3 && k == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R4 R9 rd_req waits", 64'(rd_req), 64'd1);
        chk("R4 R9 rd_addr stable", 64'(rd_addr), 64'(j * 16));
      end
      rd_valid = 1'b1;
      rd_data  = rom[j];
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data  = 8'($urandom);
    end
  endtask

  task automatic check_result(input string when);
    chk({"R7 done ", when}, 64'(done), 64'd1);
    chk("R7 rd_req low at done", 64'(rd_req), 64'd0);
    chk("R7 csum_err", 64'(csum_err), 64'(exp_err()));
    chk("R5 R6 station_addr", 64'(station_addr), 64'(exp_addr()));
  endtask

  task automatic begin_pass();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 rd_req after start", 64'(rd_req), 64'd1);
    chk("R2 base address", 64'(rd_addr), 64'd0);
    chk("R8 addr cleared", 64'(station_addr), 64'd0);
    chk("R8 err cleared", 64'(csum_err), 64'd0);
  endtask

  initial begin
    logic [47:0] held_addr;
    logic        held_err;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_req", 64'(rd_req), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 csum_err", 64'(csum_err), 64'd0);
    chk("R1 station_addr", 64'(station_addr), 64'd0);

    // stray handshake while idle
    rd_valid = 1'b1;
    rd_data  = 8'hA5;
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R4 idle valid addr", 64'(station_addr), 64'd0);
    chk("R4 idle valid req", 64'(rd_req), 64'd0);
    chk("R4 idle valid done", 64'(done), 64'd0);

    // directed: walking ones, valid checksum; R5 reversal of 8'h01 gives 8'h80
    load_rom(3);
    begin_pass();
    feed(1'b0);
    check_result("walk");
    chk("R5 top octet", 64'(station_addr[47:40]), 64'h80);
    @(negedge clk);
    chk("R7 done single", 64'(done), 64'd0);

    // directed: all zeros -> checksum error
    load_rom(2);
    begin_pass();
    feed(1'b0);
    check_result("zero");
    chk("R7 zero err", 64'(csum_err), 64'd1);
    @(negedge clk);

    for (int p = 0; p < 24; p++) begin
      load_rom(p % 2);
      begin_pass();
      feed(p % 3 == 1);
      check_result("rand");
      if (p % 4 == 2) begin
        load_rom(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 cleared after done-cycle start", 64'(station_addr), 64'd0);
        chk("R8 err cleared after done-cycle start", 64'(csum_err), 64'd0);
        chk("R7 done ended", 64'(done), 64'd0);
        chk("R2 restart req", 64'(rd_req), 64'd1);
        feed(1'b0);
        check_result("restart");
      end
      held_addr = station_addr;
      held_err  = csum_err;
      @(negedge clk);
      chk("R7 done single", 64'(done), 64'd0);
      rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R4 result held", 64'(station_addr), 64'(held_addr));
      chk("R4 err held", 64'(csum_err), 64'(held_err));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule